// File: doc/BRIEF.md
# Size-Masked Address Watchpoint Comparator

This block watches the load/store bus of a processor for one address of interest. On every valid bus cycle it compares the cycle's address against a programmed 32-bit reference. The compare is unsigned. How many low address bits take part depends on the size of the access, so a word or half-word access that covers the reference still counts as "equal".

The compare yields two raw results: equal and less-than. A programmed compare type turns them into one of four events: equal, not equal, greater than or less than. The read/write direction of the cycle must also match a programmed attribute mode: reads only, writes only, or either. When both conditions hold, the block raises a registered event bit for one clock. Debug logic further up the chip uses that bit to stop or trace the core.

Top module: `addr_watch`

## Requirements
- R1: While `rstN` is low, and in the first cycle after reset, `evtOut` is 0.
- R2: `evtOut` rises in the clock cycle after a qualifying cycle is presented with `cycValid`=1, and stays high for exactly one clock per such cycle. When `cycValid`=0, `evtOut` is 0 in the next cycle.
- R3: When `cycSize`=2'b00 (byte), all 32 address bits take part in the compare, treated as unsigned values.
- R4: When `cycSize`=2'b01 (half-word), address bit 0 is ignored on both sides of the compare.
- R5: When `cycSize`=2'b10 (word), address bits 1 and 0 are ignored on both sides. The unused code 2'b11 is handled as word.
- R6: `cfgCmpType` selects the event: 2'b00 equal, 2'b01 not equal (the inverse of equal), 2'b10 greater than, 2'b11 less than.
- R7: Greater than holds exactly when the masked values are neither equal nor less-than. Equal and less-than are never both true.
- R8: `cfgRwMode`=2'b01 accepts read cycles only (`cycWrite`=0). In this mode a write cycle produces no event.
- R9: `cfgRwMode`=2'b10 accepts write cycles only (`cycWrite`=1). In this mode a read cycle produces no event.
- R10: `cfgRwMode`=2'b00 or 2'b11 accepts both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRefAddr | input | 32 | Programmed reference address |
| cfgRwMode | input | 2 | Attribute mode: 00/11 either, 01 read, 10 write |
| cfgCmpType | input | 2 | Event type: 00 eq, 01 ne, 10 gt, 11 lt |
| cycValid | input | 1 | Bus cycle present this clock |
| cycAddr | input | 32 | Bus cycle address |
| cycSize | input | 2 | Access size: 00 byte, 01 half-word, 10/11 word |
| cycWrite | input | 1 | 1 for a write cycle, 0 for a read |
| evtOut | output | 1 | Registered match event |

## Verification
Each compare type is tried in three situations:
- addresses that differ only in bits 1:0;
- addresses that differ only in bit 0;
- addresses that differ only above bit 1.

All three are run at every access size. This shows whether the size mask is applied, and at the right width.

Two unsigned edge pairs, 0xFFFFFFFF against 0 and 0 against 0xFFFFFFFF, show whether greater-than and less-than are signed or unsigned.

Read and write cycles are each applied under all four attribute modes. This shows suppression separately from the compare result.

Idle cycles between hits, and a long run of pseudo-random cycles, confirm that the event lasts one clock and never appears without a valid cycle.

// File: rtl/addr_watch_pkg.sv
package addr_watch_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_NE = 2'b01,
    CMP_GT = 2'b10,
    CMP_LT = 2'b11
  } cmpType_e;

  typedef enum logic [1:0] {
    RW_ANY   = 2'b00,
    RW_READ  = 2'b01,
    RW_WRITE = 2'b10,
    RW_ANY2  = 2'b11
  } rwMode_e;

  // Strobes from control to datapath: which low bits drop out of the compare.
  typedef struct packed {
    logic ignoreBit1;
    logic ignoreBit0;
  } maskStrobe_t;

endpackage

// File: rtl/addr_watch_dp.sv
module addr_watch_dp
  import addr_watch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] refAddr,
  input  logic [ADDR_W-1:0] cycAddr,
  input  maskStrobe_t       strobe,
  output logic              eqRaw,
  output logic              ltRaw
);

  localparam int KEEP_W = ADDR_W - 2;

  logic [ADDR_W-1:0] keepMask;
  logic [ADDR_W-1:0] refMasked;
  logic [ADDR_W-1:0] addrMasked;

  always_comb begin
    keepMask   = {{KEEP_W{1'b1}}, ~strobe.ignoreBit1, ~strobe.ignoreBit0};
    refMasked  = refAddr & keepMask;
    addrMasked = cycAddr & keepMask;
    eqRaw      = (addrMasked == refMasked);
    ltRaw      = (addrMasked <  refMasked);
  end

  // R3: full-width equality when nothing is masked
  assert_byte_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.ignoreBit0 && !strobe.ignoreBit1 && eqRaw) |-> (cycAddr == refAddr));

  // R5: word-aligned equality whatever the low two bits
  assert_word_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ignoreBit0 && strobe.ignoreBit1 &&
     cycAddr[ADDR_W-1:2] == refAddr[ADDR_W-1:2]) |-> eqRaw);

  // R4: half-word equality whatever bit 0
  assert_half_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ignoreBit0 && !strobe.ignoreBit1 &&
     cycAddr[ADDR_W-1:1] == refAddr[ADDR_W-1:1]) |-> eqRaw);

endmodule

// File: rtl/addr_watch_ctl.sv
module addr_watch_ctl
  import addr_watch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycValid,
  input  logic [1:0]  cycSize,
  input  logic        cycWrite,
  input  logic [1:0]  cfgRwMode,
  input  logic [1:0]  cfgCmpType,
  input  logic        eqIn,
  input  logic        ltIn,
  output maskStrobe_t strobe,
  output logic        evtOut
);

  logic attrOk;
  logic typeHit;
  logic evtNext;

  always_comb begin
    strobe.ignoreBit0 = (cycSize != SZ_BYTE);
    strobe.ignoreBit1 = (cycSize == SZ_WORD) || (cycSize == SZ_RSVD);
  end

  always_comb begin
    unique case (cfgRwMode)
      RW_READ:  attrOk = !cycWrite;
      RW_WRITE: attrOk = cycWrite;
      default:  attrOk = 1'b1;
    endcase
  end

  always_comb begin
    unique case (cfgCmpType)
      CMP_EQ:  typeHit = eqIn;
      CMP_NE:  typeHit = !eqIn;
      CMP_GT:  typeHit = !eqIn && !ltIn;
      default: typeHit = ltIn;
    endcase
  end

  assign evtNext = cycValid && attrOk && typeHit;

  always_ff @(posedge clk) begin
    if (!rstN) evtOut <= 1'b0;
    else       evtOut <= evtNext;
  end

  assert_evt_needs_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    evtOut |-> $past(cycValid));

  assert_raw_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(eqIn && ltIn));

  assert_read_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evtOut && $past(cfgRwMode) == RW_READ) |-> !$past(cycWrite));

  assert_write_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    (evtOut && $past(cfgRwMode) == RW_WRITE) |-> $past(cycWrite));

  assert_eq_event_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evtOut && $past(cfgCmpType) == CMP_EQ) |-> $past(eqIn));

endmodule

// File: rtl/addr_watch.sv
module addr_watch
  import addr_watch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgRefAddr,
  input  logic [1:0]        cfgRwMode,
  input  logic [1:0]        cfgCmpType,
  input  logic              cycValid,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [1:0]        cycSize,
  input  logic              cycWrite,
  output logic              evtOut
);

  maskStrobe_t strobe;
  logic        eqRaw;
  logic        ltRaw;

  addr_watch_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cycValid   (cycValid),
    .cycSize    (cycSize),
    .cycWrite   (cycWrite),
    .cfgRwMode  (cfgRwMode),
    .cfgCmpType (cfgCmpType),
    .eqIn       (eqRaw),
    .ltIn       (ltRaw),
    .strobe     (strobe),
    .evtOut     (evtOut)
  );

  addr_watch_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .refAddr (cfgRefAddr),
    .cycAddr (cycAddr),
    .strobe  (strobe),
    .eqRaw   (eqRaw),
    .ltRaw   (ltRaw)
  );

endmodule

// File: tb/addr_watch_bench.sv
`timescale 1ns/1ps
module addr_watch_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgRefAddr = '0;
  logic [1:0]  cfgRwMode = '0;
  logic [1:0]  cfgCmpType = '0;
  logic        cycValid = 1'b0;
  logic [31:0] cycAddr = '0;
  logic [1:0]  cycSize = '0;
  logic        cycWrite = 1'b0;
  logic        evtOut;

  int applied = 0;
  int fails = 0;
  bit driverDone = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;
  item_t expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  addr_watch u_addr_watch (
    .clk(clk), .rstN(rstN), .cfgRefAddr(cfgRefAddr), .cfgRwMode(cfgRwMode),
    .cfgCmpType(cfgCmpType), .cycValid(cycValid), .cycAddr(cycAddr),
    .cycSize(cycSize), .cycWrite(cycWrite), .evtOut(evtOut)
  );

  function automatic bit model(input logic [31:0] r, input logic [31:0] a,
                               input logic [1:0] sz, input logic wr,
                               input logic [1:0] mode, input logic [1:0] ct,
                               input logic v);
    logic [31:0] m;
    bit eq, lt, hit, ok;
    m  = (sz == 2'b00) ? 32'hFFFF_FFFF : (sz == 2'b01) ? 32'hFFFF_FFFE : 32'hFFFF_FFFC;
    eq = ((a & m) == (r & m));
    lt = ((a & m) <  (r & m));
    case (ct)
      2'b00: hit = eq;
      2'b01: hit = !eq;
      2'b10: hit = !eq && !lt;
      default: hit = lt;
    endcase
    ok = (mode == 2'b01) ? !wr : (mode == 2'b10) ? wr : 1'b1;
    return v && ok && hit;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: evtOut=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] r, input logic [31:0] a, input logic [1:0] sz,
                       input logic wr, input logic [1:0] mode, input logic [1:0] ct,
                       input logic v, input string tag);
    item_t it;
    @(negedge clk);
    cfgRefAddr = r; cycAddr = a; cycSize = sz; cycWrite = wr;
    cfgRwMode = mode; cfgCmpType = ct; cycValid = v;
    it.exp = model(r, a, sz, wr, mode, ct, v);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: sample 2 ns after the edge that registers each vector
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(evtOut, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog R2: run did not finish, actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(evtOut, 1'b0, "R1 reset");
    cycValid = 1'b1; cfgCmpType = 2'b01; cycAddr = 32'h5;
    @(negedge clk);
    check(evtOut, 1'b0, "R1 reset with valid");
    cycValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(evtOut, 1'b0, "R1 first cycle after reset");

    // R6/R3/R4/R5: every compare type at every size on boundary offsets
    for (int ct = 0; ct < 4; ct++) begin
      for (int sz = 0; sz < 4; sz++) begin
        drive(32'h1000_0004, 32'h1000_0004, sz[1:0], 1'b0, 2'b00, ct[1:0], 1'b1, "R6 same");
        drive(32'h1000_0004, 32'h1000_0005, sz[1:0], 1'b0, 2'b00, ct[1:0], 1'b1, "R4 bit0 diff");
        drive(32'h1000_0004, 32'h1000_0006, sz[1:0], 1'b0, 2'b00, ct[1:0], 1'b1, "R5 bit1 diff");
        drive(32'h1000_0007, 32'h1000_0004, sz[1:0], 1'b0, 2'b00, ct[1:0], 1'b1, "R5 low below");
        drive(32'h1000_0004, 32'h1000_0008, sz[1:0], 1'b1, 2'b00, ct[1:0], 1'b1, "R3 upper diff");
        drive(32'h1000_0004, 32'h1000_0004, sz[1:0], 1'b0, 2'b00, ct[1:0], 1'b0, "R2 idle");
      end
    end

    // R7: unsigned extremes
    drive(32'h0000_0000, 32'hFFFF_FFFF, 2'b00, 1'b0, 2'b00, 2'b10, 1'b1, "R7 gt unsigned");
    drive(32'h0000_0000, 32'hFFFF_FFFF, 2'b00, 1'b0, 2'b00, 2'b11, 1'b1, "R7 not lt");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 2'b00, 1'b0, 2'b00, 2'b11, 1'b1, "R3 lt unsigned");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 2'b00, 1'b0, 2'b00, 2'b10, 1'b1, "R7 not gt");

    // R8/R9/R10: attribute modes with matching address
    for (int md = 0; md < 4; md++) begin
      drive(32'hA0, 32'hA0, 2'b10, 1'b0, md[1:0], 2'b00, 1'b1, "R8 R10 read cycle");
      drive(32'hA0, 32'hA0, 2'b10, 1'b1, md[1:0], 2'b00, 1'b1, "R9 R10 write cycle");
    end

    // R2: back-to-back hits then idle gap
    drive(32'h40, 32'h40, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, "R2 hit a");
    drive(32'h40, 32'h40, 2'b00, 1'b0, 2'b00, 2'b00, 1'b1, "R2 hit b");
    drive(32'h40, 32'h40, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, "R2 drop");
    drive(32'h40, 32'h40, 2'b00, 1'b0, 2'b00, 2'b00, 1'b0, "R2 stay low");

    // Pseudo-random run across all fields
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r, a;
      logic [31:0] rnd;
      rnd = $urandom;
      r = $urandom;
      a = rnd[0] ? (r ^ {30'b0, rnd[2:1]}) : $urandom;
      drive(r, a, rnd[4:3], rnd[5], rnd[7:6], rnd[9:8], rnd[10] | rnd[11], "R2 R6 random");
    end

    driverDone = 1'b1;
    @(negedge clk);
    cycValid = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule